// File: doc/BRIEF.md
# Iterative Stencil Tile Restorer

This block cleans up one small image tile that sits entirely in on-chip storage. A host streams the degraded tile in, pixel by pixel in raster order. The tile is a core region with a guard band of `OVL` pixels on all four sides. A pulse on `start`, together with an iteration count, then runs that many Jacobi sweeps of a 3x3 stencil over the whole tile. Each sweep updates every pixel in turn.

Each new pixel value combines three terms: a scaled copy of the untouched degraded pixel, the pixel's current value, and the negative of a weighted neighbourhood term. The neighbourhood term weights the eight surrounding pixels with one coefficient and the centre pixel with another. When the sweeps finish, only the core region is streamed out and the guard band is thrown away. The host is expected to cut a large image into overlapping tiles and stitch the streamed cores back together.

Both streams use valid/ready handshakes. On the input stream, a pixel is taken on any clock edge where `ld_valid` and `ld_ready` are both high. On the output stream, a pixel is taken on any clock edge where `out_valid` and `out_ready` are both high. The output honours back-pressure: while it is stalled, it holds its pixel and flags unchanged. `start`, `iter_count` and `done` are plain level/pulse pins.

Top module: `stencil_restorer`

## Requirements
- R1: `ld_ready` is high exactly while the block is idle, including right after reset. The accepted pixels fill the tile in raster order: row 0 first, columns left to right, `TW = CORE_W+2*OVL` pixels per row and `TH = CORE_H+2*OVL` rows. After `TW*TH` accepted pixels, the write position wraps back to row 0, column 0.
- R2: Let Y be the degraded pixel, X the current value, S8 the sum of the eight neighbours, and the coefficients signed Q2.8 integers (`CY`, `CN`, `CC`). Each new pixel is `floor((CY*Y + 256*X - CN*S8 - CC*X + 128) / 256)`, clamped to the range 0..255.
- R3: A neighbour lying outside the tile takes the value of the nearest tile pixel. In other words, its row and its column are each clamped into the tile.
- R4: Every pixel of a sweep is computed only from the previous sweep's values. The degraded tile never changes while the block runs. The first sweep starts from the degraded tile, so a second `start` with no reload in between repeats the same result.
- R5: `iter_count` is sampled on the edge that captures `start`. A count of zero streams out the degraded core unchanged.
- R6: The output carries exactly the `CORE_W*CORE_H` core pixels, in raster order over the core. `out_last` is high only together with `out_valid`, and only on the final core pixel.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and keeps `out_pixel` and `out_last` unchanged.
- R8: `done` is high for exactly one cycle: the cycle right after the final core pixel is accepted. The block is idle again from that cycle on.
- R9: Count the rising edges starting with the edge that captures `start`. `out_valid` first goes high after edge number `iter_count*TW*TH + 1`.
- R10: While the block is busy, `ld_ready` is low. Any `ld_valid` or `start` seen during that time is ignored and does not change the tile or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load pixel offered |
| ld_ready | output | 1 | Load pixel can be taken (idle) |
| ld_pixel | input | PIX_W | Degraded tile pixel, raster order |
| start | input | 1 | Begin a restore run (taken when idle) |
| iter_count | input | ITER_W | Number of sweeps for this run |
| done | output | 1 | One-cycle pulse after the final core pixel is taken |
| out_valid | output | 1 | Restored core pixel offered |
| out_ready | input | 1 | Consumer takes the offered pixel |
| out_pixel | output | PIX_W | Restored core pixel |
| out_last | output | 1 | Marks the final core pixel |

## Verification
The bench checks every streamed pixel against a behavioural reference model of the sweeps. It drives inputs chosen to push the result past both clamp limits. A datapath with a wrong rounding offset, or with saturation missing, would then miscompare on exactly those pixels. A single bright corner pixel and a gradient test the edge replication: index wrap-around or zero padding would disturb the border results. Repeating a run without a reload catches two faults: a design that writes results into the array it is still reading (Gauss-Seidel), and a design that starts the second run from stale iterates. Junk loads and junk starts during a run, random back-pressure, and the latency and `done` timing checks expose a datapath that leaks or drops pixels when stalled, or that miscounts sweeps.

// File: rtl/irst_pkg.sv
`timescale 1ns/1ps
package irst_pkg;
  typedef enum logic [1:0] {SRC_DEG = 2'd0, SRC_B0 = 2'd1, SRC_B1 = 2'd2} src_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_OUT = 2'd2} state_e;
endpackage

// File: rtl/irst_tile_mem.sv
`timescale 1ns/1ps
module irst_tile_mem
  import irst_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int TW    = 6,
  parameter int TH    = 6,
  localparam int NPIX = TW * TH,
  localparam int AW   = $clog2(NPIX),
  localparam int RW   = $clog2(TH),
  localparam int CW   = $clog2(TW),
  localparam int SW   = PIX_W + 3
) (
  input  logic             clk,
  input  logic             ld_we,
  input  logic [AW-1:0]    ld_addr,
  input  logic [PIX_W-1:0] ld_data,
  input  logic             it_we,
  input  logic             it_bank,
  input  logic [AW-1:0]    it_addr,
  input  logic [PIX_W-1:0] it_data,
  input  src_e             rd_src,
  input  logic [RW-1:0]    rd_row,
  input  logic [CW-1:0]    rd_col,
  output logic [PIX_W-1:0] ctr_pix,
  output logic [PIX_W-1:0] deg_pix,
  output logic [SW-1:0]    nsum
);
  logic [PIX_W-1:0] deg_q  [NPIX];
  logic [PIX_W-1:0] bank_q [2][NPIX];

  always_ff @(posedge clk) begin
    if (ld_we) deg_q[ld_addr] <= ld_data;
    if (it_we) bank_q[it_bank][it_addr] <= it_data;
  end

  function automatic logic [PIX_W-1:0] fetch(src_e s, logic [AW-1:0] a);
    case (s)
      SRC_B0:  return bank_q[0][a];
      SRC_B1:  return bank_q[1][a];
      default: return deg_q[a];
    endcase
  endfunction

  always_comb begin
    int r;
    int c;
    logic [AW-1:0] a;
    logic [PIX_W-1:0] pv;
    nsum    = '0;
    ctr_pix = '0;
    deg_pix = '0;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        r = int'(rd_row) + dr;
        c = int'(rd_col) + dc;
        if (r < 0) r = 0;
        if (r > TH - 1) r = TH - 1;
        if (c < 0) c = 0;
        if (c > TW - 1) c = TW - 1;
        a  = AW'(r * TW + c);
        pv = fetch(rd_src, a);
        if (dr == 0 && dc == 0) begin
          ctr_pix = pv;
          deg_pix = deg_q[a];
        end else begin
          nsum = nsum + SW'(pv);
        end
      end
    end
  end
endmodule

// File: rtl/irst_stencil_alu.sv
`timescale 1ns/1ps
module irst_stencil_alu #(
  parameter int PIX_W = 8,
  parameter int CF_W  = 10,
  parameter int CY    = 64,
  parameter int CN    = 32,
  parameter int CC    = -64,
  localparam int FRAC = CF_W - 2,
  localparam int SW   = PIX_W + 3,
  localparam int AW   = PIX_W + CF_W + 6
) (
  input  logic [PIX_W-1:0] y_pix,
  input  logic [PIX_W-1:0] x_pix,
  input  logic [SW-1:0]    nsum,
  output logic [PIX_W-1:0] result
);
  localparam logic signed [AW-1:0] CY_E  = AW'(CY);
  localparam logic signed [AW-1:0] CN_E  = AW'(CN);
  localparam logic signed [AW-1:0] CC_E  = AW'(CC);
  localparam logic signed [AW-1:0] HALF  = AW'(1 << (FRAC - 1));
  localparam logic signed [AW-1:0] PMAX  = AW'((1 << PIX_W) - 1);

  logic signed [AW-1:0] ys, xs, ns, acc, shr;

  always_comb begin
    ys  = $signed(AW'(y_pix));
    xs  = $signed(AW'(x_pix));
    ns  = $signed(AW'(nsum));
    acc = CY_E * ys + (xs <<< FRAC) - CN_E * ns - CC_E * xs + HALF;
    shr = acc >>> FRAC;
    if (shr < 0)         result = '0;
    else if (shr > PMAX) result = '1;
    else                 result = shr[PIX_W-1:0];
  end
endmodule

// File: rtl/irst_ctrl.sv
`timescale 1ns/1ps
module irst_ctrl
  import irst_pkg::*;
#(
  parameter int CORE_W = 4,
  parameter int CORE_H = 4,
  parameter int OVL    = 1,
  parameter int ITER_W = 8,
  localparam int TW    = CORE_W + 2 * OVL,
  localparam int TH    = CORE_H + 2 * OVL,
  localparam int NPIX  = TW * TH,
  localparam int AW    = $clog2(NPIX),
  localparam int RW    = $clog2(TH),
  localparam int CW    = $clog2(TW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  output logic              ld_we,
  output logic [AW-1:0]     ld_addr,
  input  logic              start,
  input  logic [ITER_W-1:0] iter_count,
  output logic              it_we,
  output logic              it_bank,
  output logic [AW-1:0]     it_addr,
  output src_e              rd_src,
  output logic [RW-1:0]     rd_row,
  output logic [CW-1:0]     rd_col,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic              done
);
  state_e            st;
  logic [AW-1:0]     lcnt;
  logic [RW-1:0]     row;
  logic [CW-1:0]     col;
  logic [ITER_W-1:0] remain;
  logic              wbank;
  src_e              src;
  logic              done_q;

  logic tile_end, core_col_end, core_row_end, fire;

  assign tile_end     = (row == RW'(TH - 1)) && (col == CW'(TW - 1));
  assign core_col_end = (col == CW'(CORE_W - 1));
  assign core_row_end = (row == RW'(CORE_H - 1));
  assign fire         = out_valid && out_ready;

  assign ld_ready  = (st == ST_IDLE);
  assign ld_we     = ld_ready && ld_valid;
  assign ld_addr   = lcnt;
  assign it_we     = (st == ST_RUN);
  assign it_bank   = wbank;
  assign it_addr   = AW'(row) * AW'(TW) + AW'(col);
  assign rd_src    = src;
  assign rd_row    = (st == ST_OUT) ? row + RW'(OVL) : row;
  assign rd_col    = (st == ST_OUT) ? col + CW'(OVL) : col;
  assign out_valid = (st == ST_OUT);
  assign out_last  = out_valid && core_col_end && core_row_end;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      lcnt   <= '0;
      row    <= '0;
      col    <= '0;
      remain <= '0;
      wbank  <= 1'b0;
      src    <= SRC_DEG;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (ld_we) lcnt <= (lcnt == AW'(NPIX - 1)) ? '0 : lcnt + 1'b1;
          if (start) begin
            row    <= '0;
            col    <= '0;
            wbank  <= 1'b0;
            src    <= SRC_DEG;
            remain <= iter_count;
            st     <= (iter_count == '0) ? ST_OUT : ST_RUN;
          end
        end
        ST_RUN: begin
          if (tile_end) begin
            row    <= '0;
            col    <= '0;
            wbank  <= ~wbank;
            src    <= wbank ? SRC_B1 : SRC_B0;
            remain <= remain - 1'b1;
            if (remain == ITER_W'(1)) st <= ST_OUT;
          end else if (col == CW'(TW - 1)) begin
            col <= '0;
            row <= row + 1'b1;
          end else begin
            col <= col + 1'b1;
          end
        end
        ST_OUT: begin
          if (fire) begin
            if (core_col_end) begin
              col <= '0;
              if (core_row_end) begin
                row    <= '0;
                st     <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                row <= row + 1'b1;
              end
            end else begin
              col <= col + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  run_has_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (remain != '0));

  // R4
  no_self_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (src != (wbank ? SRC_B1 : SRC_B0)));

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && start && !tile_end) |=> (st == ST_RUN && $stable(remain)));
endmodule

// File: rtl/stencil_restorer.sv
`timescale 1ns/1ps
module stencil_restorer
  import irst_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int CORE_W = 4,
  parameter int CORE_H = 4,
  parameter int OVL    = 1,
  parameter int ITER_W = 8,
  parameter int CF_W   = 10,
  parameter int CY     = 64,
  parameter int CN     = 32,
  parameter int CC     = -64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [PIX_W-1:0]  ld_pixel,
  input  logic              start,
  input  logic [ITER_W-1:0] iter_count,
  output logic              done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pixel,
  output logic              out_last
);
  localparam int TW   = CORE_W + 2 * OVL;
  localparam int TH   = CORE_H + 2 * OVL;
  localparam int NPIX = TW * TH;
  localparam int AW   = $clog2(NPIX);
  localparam int RW   = $clog2(TH);
  localparam int CW   = $clog2(TW);
  localparam int SW   = PIX_W + 3;

  logic             ld_we, it_we, it_bank;
  logic [AW-1:0]    ld_addr, it_addr;
  src_e             rd_src;
  logic [RW-1:0]    rd_row;
  logic [CW-1:0]    rd_col;
  logic [PIX_W-1:0] ctr_pix, deg_pix, new_pix;
  logic [SW-1:0]    nsum;

  irst_ctrl #(
    .CORE_W(CORE_W), .CORE_H(CORE_H), .OVL(OVL), .ITER_W(ITER_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_we(ld_we), .ld_addr(ld_addr),
    .start(start), .iter_count(iter_count),
    .it_we(it_we), .it_bank(it_bank), .it_addr(it_addr),
    .rd_src(rd_src), .rd_row(rd_row), .rd_col(rd_col),
    .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
    .done(done)
  );

  irst_tile_mem #(.PIX_W(PIX_W), .TW(TW), .TH(TH)) u_mem (
    .clk(clk),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_pixel),
    .it_we(it_we), .it_bank(it_bank), .it_addr(it_addr), .it_data(new_pix),
    .rd_src(rd_src), .rd_row(rd_row), .rd_col(rd_col),
    .ctr_pix(ctr_pix), .deg_pix(deg_pix), .nsum(nsum)
  );

  irst_stencil_alu #(
    .PIX_W(PIX_W), .CF_W(CF_W), .CY(CY), .CN(CN), .CC(CC)
  ) u_alu (
    .y_pix(deg_pix), .x_pix(ctr_pix), .nsum(nsum), .result(new_pix)
  );

  assign out_pixel = ctr_pix;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) && $stable(out_last)));

  // R6
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R8
  done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (done && ld_ready));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  load_vs_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_ready && out_valid));
endmodule

// File: tb/stencil_restorer_test.sv
`timescale 1ns/1ps
module stencil_restorer_test;
  localparam int CORE_W = 4, CORE_H = 4, OVL = 1;
  localparam int TW = CORE_W + 2 * OVL, TH = CORE_H + 2 * OVL;
  localparam int NPIX = TW * TH, NCORE = CORE_W * CORE_H;
  localparam int KY = 64, KN = 32, KC = -64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [7:0] ld_pixel = '0, iter_count = '0;
  logic ld_ready, done, out_valid, out_last;
  logic [7:0] out_pixel;

  int nvec = 0, nbad = 0;
  int deg [NPIX];
  int expq [$];
  int lfsr = 32'h1ACE;

  always #4 clk = ~clk;

  stencil_restorer uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_pixel(ld_pixel), .start(start), .iter_count(iter_count), .done(done),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
    .out_last(out_last)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clampi(int v, int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  // R2 R3 R4 reference: Jacobi sweeps from the degraded tile
  task automatic build_expect(int iters);
    int cur [NPIX];
    int nxt [NPIX];
    cur = deg;
    for (int k = 0; k < iters; k++) begin
      for (int r = 0; r < TH; r++) begin
        for (int c = 0; c < TW; c++) begin
          int s8 = 0;
          int acc, q;
          for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
              if (dr != 0 || dc != 0)
                s8 += cur[clampi(r + dr, TH - 1) * TW + clampi(c + dc, TW - 1)];
          acc = KY * deg[r*TW+c] + 256 * cur[r*TW+c] - KN * s8 - KC * cur[r*TW+c] + 128;
          q = acc >>> 8;
          nxt[r*TW+c] = clampi(q, 255);
        end
      end
      cur = nxt;
    end
    expq.delete();
    for (int r = 0; r < CORE_H; r++)
      for (int c = 0; c < CORE_W; c++)
        expq.push_back(cur[(r + OVL) * TW + c + OVL]);
  endtask

  task automatic load_tile(int kind);
    for (int p = 0; p < NPIX; p++) begin
      int r = p / TW, c = p % TW;
      case (kind)
        0: deg[p] = (r * 40 + c * 7) % 256;
        1: deg[p] = ((r + c) % 2) ? 255 : 0;
        2: deg[p] = (p * 73 + 11) % 256;
        default: deg[p] = (p == 0) ? 255 : 0;
      endcase
    end
    for (int p = 0; p < NPIX; p++) begin
      if (p % 5 == 3) begin
        @(negedge clk); ld_valid = 1'b0;
      end
      @(negedge clk);
      ld_valid = 1'b1; ld_pixel = 8'(deg[p]);
      chk(ld_ready == 1'b1, "R1 ld_ready idle", int'(ld_ready), 1);
    end
    @(negedge clk); ld_valid = 1'b0;
  endtask

  // rmode 0: always ready, 1: alternate, 2: pseudo-random
  task automatic run_tile(int iters, int rmode, bit junk, string tag);
    int lat, idx, prev_pix;
    bit prev_stall;
    build_expect(iters);
    @(negedge clk); start = 1'b1; iter_count = 8'(iters);
    @(negedge clk); start = 1'b0; iter_count = 8'(iters + 3); lat = 1;
    while (!out_valid && lat < 20000) begin
      if (junk) begin
        ld_valid = 1'b1; ld_pixel = 8'hA5; start = 1'b1;
        chk(ld_ready == 1'b0, "R10 ld_ready busy", int'(ld_ready), 0);
      end
      @(negedge clk); lat++;
    end
    ld_valid = 1'b0; start = 1'b0;
    chk(lat == iters * NPIX + 1, {"R9 latency ", tag}, lat, iters * NPIX + 1);
    idx = 0; prev_stall = 1'b0; prev_pix = 0;
    while (idx < NCORE && lat < 40000) begin
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = (lat % 2) == 0;
        default: begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          out_ready = lfsr[3] | lfsr[7];
        end
      endcase
      if (prev_stall)
        chk(out_valid && out_pixel == 8'(prev_pix), "R7 stall hold", int'(out_pixel), prev_pix);
      chk(done == 1'b0, "R8 done early", int'(done), 0);
      if (out_valid && out_ready) begin
        chk(int'(out_pixel) == expq[idx], {"R2 R4 pixel ", tag}, int'(out_pixel), expq[idx]);
        chk(out_last == (idx == NCORE - 1), "R6 last flag", int'(out_last), int'(idx == NCORE - 1));
        idx++;
      end
      prev_stall = out_valid && !out_ready;
      prev_pix = int'(out_pixel);
      @(negedge clk); lat++;
    end
    out_ready = 1'b0;
    chk(done == 1'b1, "R8 done pulse", int'(done), 1);
    chk(out_valid == 1'b0, "R6 stream ended", int'(out_valid), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    chk(ld_ready == 1'b1, "R8 idle again", int'(ld_ready), 1);
  endtask

  initial begin
    #1200000;
    nbad++; nvec++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ld_ready == 1'b1, "R1 reset ld_ready", int'(ld_ready), 1);
    chk(out_valid == 1'b0, "R6 reset out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R8 reset done", int'(done), 0);
    rst_n = 1'b1;
    load_tile(0);
    run_tile(3, 0, 1'b0, "gradient x3");
    run_tile(0, 1, 1'b0, "R5 zero sweeps");
    load_tile(1);
    run_tile(2, 2, 1'b1, "checker x2 R10 junk");
    run_tile(2, 0, 1'b0, "R4 rerun no reload");
    load_tile(2);
    run_tile(5, 2, 1'b0, "hash x5");
    load_tile(3);
    run_tile(1, 1, 1'b0, "R3 corner spike");
    run_tile(4, 2, 1'b1, "R3 corner spike x4");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule